// File: doc/BRIEF.md
# Chained Transmit Descriptor Fetcher

This block is the transmit-side DMA engine of an Ethernet controller. Software builds a linked list of descriptors in memory. Each descriptor has four 32-bit words: status, control/size, buffer pointer and next pointer. Software hands a descriptor to the engine by setting the top bit of its status word. Once started, the engine reads the descriptor and checks that bit. It then reads the buffer in word bursts of bounded size and collects the bytes into a local frame store. Next it writes the status word back with the hand-over bit cleared, and moves on by loading the next pointer.

A frame may span several descriptors. The control word marks which segment opens a frame and which one closes it. Output is store-and-forward. The assembled frame is streamed as bytes, with first and last markers, only after its closing segment has been read and written back. The engine fetches nothing further until that frame has fully left.

The engine stops in an idle state in two cases: when it meets a descriptor it does not own, or at a descriptor boundary when the enable is low. A start pulse resumes it at the current descriptor address. That address is also visible on an output for debug.

Top module: `txd_chain_fetch`

## Requirements
- R1: After reset, `cur_desc` is 0, `mem_req_valid` is low and `out_valid` is low.
- R2: A `base_wr` pulse while idle loads `base_addr` into `cur_desc`. A `start` pulse with `enable` high then issues one 4-word read burst at `cur_desc`. The four beats are taken in order as status, control/size, buffer pointer, next pointer. A request holds its address and length until `mem_req_ready`.
- R3: If the fetched status word has bit 31 clear, the engine issues no further request, keeps `cur_desc` unchanged and stays idle until the next `start`.
- R4: The segment length is control bits 10:0. The engine reads ceil(length/4) words from consecutive addresses, starting at the buffer pointer with bits 1:0 forced to zero. It uses bursts of min(remaining words, 8), and `mem_req_len` gives the word count of each burst.
- R5: Within a word, bytes are emitted little-endian: bits 7:0 first. Only the first `length` bytes of a segment are emitted.
- R6: After a segment's data is read, the engine issues one write of the status word, with bit 31 cleared and all other bits kept, to the descriptor's address. It then loads the next-pointer word into `cur_desc`.
- R7: A segment of length 0 causes no buffer read, but its status is still written back.
- R8: Control bit 29 starts a new frame and control bit 30 closes it. The bytes of all segments of a frame come out back to back. `out_first` is high only on the first byte and `out_last` is high only on the final byte. Bytes past FRAME_BYTES in one frame are dropped.
- R9: No byte is presented before the closing segment's write-back has been accepted. No next descriptor is fetched until the frame's last byte has been accepted.
- R10: `start` is ignored while `enable` is low. Clearing `enable` during a descriptor lets that descriptor finish (write-back included), then stops with `cur_desc` at its next pointer.
- R11: The chain wraps only through next pointers. A `start` pulse without `base_wr` resumes at the current `cur_desc`.
- R12: While `out_valid` is high and `out_ready` low, `out_valid`, `out_data` and the markers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable, checked at descriptor boundaries |
| start | input | 1 | Resume pulse, acted on when idle |
| base_wr | input | 1 | Load `base_addr` into the current pointer when idle |
| base_addr | input | 32 | First descriptor address |
| cur_desc | output | 32 | Current descriptor address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = single-word write, 0 = burst read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_len | output | 4 | Words in the burst (1 for writes) |
| mem_req_wdata | output | 32 | Write data |
| mem_rd_valid | input | 1 | Read beat valid, in request order |
| mem_rd_data | input | 32 | Read beat data |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Final byte of a frame |

## Verification
The bench drives these cases:
- A single 37-byte segment, which needs an 8-word burst followed by a 2-word tail and ends on a partial word. This separates correct burst splitting and byte trimming from off-by-one counts.
- A three-segment frame with a zero-length middle segment, run with request stalls, gapped read data and output back-pressure. It shows concatenation across segments, the skipped data phase, and that output waits for the closing write-back and fetching waits for the drain.
- A zero-length single-segment frame.
- A chain interrupted by dropping `enable`.
- A two-entry loop that wraps onto a descriptor already handed back, and is then resumed by `start` alone. Together these separate stopping on ownership from stopping on enable, and resuming at the current pointer from reloading the base.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int TXD_OWN_BIT   = 31;
    localparam int TXD_LAST_BIT  = 30;
    localparam int TXD_FIRST_BIT = 29;
    localparam int TXD_DESC_WORDS = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DREQ,
        S_DRSP,
        S_CHECK,
        S_BREQ,
        S_BRSP,
        S_WB,
        S_DRAIN,
        S_NEXT
    } txd_state_e;

    typedef struct packed {
        logic [31:0] status;
        logic [31:0] ctrl;
        logic [31:0] bufp;
        logic [31:0] nextp;
    } txd_desc_t;

endpackage

// File: rtl/txd_burst_plan.sv
module txd_burst_plan #(
    parameter int MAX_BURST = 8,
    parameter int WC_W      = 10,
    localparam int BL_W     = $clog2(MAX_BURST + 1)
) (
    input  logic [WC_W-1:0] rem_words,
    output logic [BL_W-1:0] burst_words,
    output logic            final_burst
);

    always_comb begin
        final_burst = (rem_words <= WC_W'(MAX_BURST));
        if (final_burst) begin
            burst_words = BL_W'(rem_words);
        end else begin
            burst_words = BL_W'(MAX_BURST);
        end
    end

endmodule

// File: rtl/txd_frame_buf.sv
module txd_frame_buf #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        push,
    input  logic [31:0] push_word,
    input  logic [2:0]  push_n,
    input  logic        commit,
    output logic        sending,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_first,
    output logic        out_last
);

    typedef struct packed {
        logic [AW:0] wptr;
        logic [AW:0] rptr;
        logic        snd;
    } fb_t;

    fb_t q, n;
    logic [7:0] store [DEPTH];
    int wsum;
    logic at_end;

    assign at_end = (q.rptr == q.wptr - (AW+1)'(1));

    always_comb begin
        n = q;
        wsum = int'(q.wptr) + int'(push_n);
        if (clr) begin
            n.wptr = '0;
        end
        if (push) begin
            n.wptr = (wsum > DEPTH) ? (AW+1)'(DEPTH) : (AW+1)'(wsum);
        end
        if (commit) begin
            n.rptr = '0;
            n.snd  = (q.wptr != '0);
        end
        if (q.snd && out_ready) begin
            if (at_end) begin
                n.snd  = 1'b0;
                n.wptr = '0;
                n.rptr = '0;
            end else begin
                n.rptr = q.rptr + (AW+1)'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (push && (i < int'(push_n)) && ((int'(q.wptr) + i) < DEPTH)) begin
                store[AW'(int'(q.wptr) + i)] <= push_word[8*i +: 8];
            end
        end
    end

    assign sending   = q.snd;
    assign out_valid = q.snd;
    assign out_data  = store[q.rptr[AW-1:0]];
    assign out_first = q.snd && (q.rptr == '0);
    assign out_last  = q.snd && at_end;

    // R8: bytes are never appended while a finished frame is leaving
    a_r8_no_push_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !q.snd);

    // R12: output holds under back-pressure
    a_r12_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_first)));

endmodule

// File: rtl/txd_chain_fetch.sv
module txd_chain_fetch
    import txd_pkg::*;
#(
    parameter int MAX_BURST   = 8,
    parameter int FRAME_BYTES = 256,
    parameter int LEN_W       = 11,
    localparam int BL_W       = $clog2(MAX_BURST + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            start,
    input  logic            base_wr,
    input  logic [31:0]     base_addr,
    output logic [31:0]     cur_desc,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_write,
    output logic [31:0]     mem_req_addr,
    output logic [BL_W-1:0] mem_req_len,
    output logic [31:0]     mem_req_wdata,
    input  logic            mem_rd_valid,
    input  logic [31:0]     mem_rd_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [7:0]      out_data,
    output logic            out_first,
    output logic            out_last
);

    localparam int WC_W = LEN_W - 1;

    typedef struct packed {
        txd_state_e      st;
        logic [31:0]     cur;
        txd_desc_t       d;
        logic [1:0]      dbeat;
        logic [31:0]     baddr;
        logic [WC_W-1:0] rem_w;
        logic [LEN_W-1:0] rem_b;
        logic [BL_W-1:0] blen;
        logic [BL_W-1:0] bbeat;
    } ctx_t;

    ctx_t q, n;

    logic [BL_W-1:0]  plan_words;
    logic             plan_final;
    logic             fb_clr, fb_push, fb_commit, fb_sending;
    logic [2:0]       fb_n;
    logic [LEN_W-1:0] seg_len;
    logic [LEN_W:0]   seg_round;

    assign seg_len   = q.d.ctrl[LEN_W-1:0];
    assign seg_round = {1'b0, seg_len} + (LEN_W+1)'(3);

    txd_burst_plan #(
        .MAX_BURST (MAX_BURST),
        .WC_W      (WC_W)
    ) u_plan (
        .rem_words   (q.rem_w),
        .burst_words (plan_words),
        .final_burst (plan_final)
    );

    always_comb begin
        n             = q;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_len   = '0;
        mem_req_wdata = '0;
        fb_clr        = 1'b0;
        fb_push       = 1'b0;
        fb_commit     = 1'b0;
        fb_n          = (q.rem_b >= LEN_W'(4)) ? 3'd4 : q.rem_b[2:0];

        case (q.st)
            S_IDLE: begin
                if (base_wr) begin
                    n.cur = base_addr;
                end
                if (start && enable) begin
                    n.st = S_DREQ;
                end
            end
            S_DREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = q.cur;
                mem_req_len   = BL_W'(TXD_DESC_WORDS);
                if (mem_req_ready) begin
                    n.st    = S_DRSP;
                    n.dbeat = '0;
                end
            end
            S_DRSP: begin
                if (mem_rd_valid) begin
                    case (q.dbeat)
                        2'd0:    n.d.status = mem_rd_data;
                        2'd1:    n.d.ctrl   = mem_rd_data;
                        2'd2:    n.d.bufp   = mem_rd_data;
                        default: n.d.nextp  = mem_rd_data;
                    endcase
                    n.dbeat = q.dbeat + 2'd1;
                    if (q.dbeat == 2'd3) begin
                        n.st = S_CHECK;
                    end
                end
            end
            S_CHECK: begin
                if (!q.d.status[TXD_OWN_BIT]) begin
                    n.st = S_IDLE;
                end else begin
                    fb_clr  = q.d.ctrl[TXD_FIRST_BIT];
                    n.rem_b = seg_len;
                    n.rem_w = seg_round[LEN_W:2];
                    n.baddr = {q.d.bufp[31:2], 2'b00};
                    n.st    = (seg_len == '0) ? S_WB : S_BREQ;
                end
            end
            S_BREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = q.baddr;
                mem_req_len   = plan_words;
                if (mem_req_ready) begin
                    n.blen  = plan_words;
                    n.bbeat = '0;
                    n.st    = S_BRSP;
                end
            end
            S_BRSP: begin
                if (mem_rd_valid) begin
                    fb_push = 1'b1;
                    n.rem_b = q.rem_b - LEN_W'(fb_n);
                    n.baddr = q.baddr + 32'd4;
                    n.bbeat = q.bbeat + BL_W'(1);
                    if (q.bbeat == q.blen - BL_W'(1)) begin
                        n.rem_w = q.rem_w - WC_W'(q.blen);
                        n.st    = plan_final ? S_WB : S_BREQ;
                    end
                end
            end
            S_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = q.cur;
                mem_req_len   = BL_W'(1);
                mem_req_wdata = q.d.status & ~(32'd1 << TXD_OWN_BIT);
                if (mem_req_ready) begin
                    if (q.d.ctrl[TXD_LAST_BIT]) begin
                        fb_commit = 1'b1;
                        n.st      = S_DRAIN;
                    end else begin
                        n.st = S_NEXT;
                    end
                end
            end
            S_DRAIN: begin
                if (!fb_sending) begin
                    n.st = S_NEXT;
                end
            end
            S_NEXT: begin
                n.cur = q.d.nextp;
                n.st  = enable ? S_DREQ : S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign cur_desc = q.cur;

    txd_frame_buf #(
        .DEPTH (FRAME_BYTES)
    ) u_fbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fb_clr),
        .push      (fb_push),
        .push_word (mem_rd_data),
        .push_n    (fb_n),
        .commit    (fb_commit),
        .sending   (fb_sending),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_first (out_first),
        .out_last  (out_last)
    );

    // R4: every burst carries between one and MAX_BURST words
    a_r4_burst_limit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_len != '0 && mem_req_len <= BL_W'(MAX_BURST)));

    // R2: a stalled request keeps its address, length and direction
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
                                               && $stable(mem_req_len) && $stable(mem_req_write)));

    // R6: a write-back always hands the descriptor back to software
    a_r6_owner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> !mem_req_wdata[TXD_OWN_BIT]);

    // R9: bytes only leave while the fetcher waits for the drain
    a_r9_output_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (q.st == S_DRAIN && !mem_req_valid));

endmodule

// File: tb/txd_chain_fetch_test.sv
`timescale 1ns/1ps
module txd_chain_fetch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        start = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] cur_desc;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic [3:0]  mem_req_len;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        out_valid, out_first, out_last;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;

    always #10 clk = ~clk;

    txd_chain_fetch uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .base_wr(base_wr), .base_addr(base_addr), .cur_desc(cur_desc),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_len(mem_req_len), .mem_req_wdata(mem_req_wdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] mem_w [1024];
    logic [31:0] rq [$];
    bit stall_mode = 0, gap_mode = 0, oback = 0;
    bit rtog = 0, gtog = 0, otog = 0;

    logic [31:0] rd_addr [64];
    int          rd_len  [64];
    int          rd_cyc  [64];
    int          n_rd = 0;
    logic [31:0] wr_addr [16];
    logic [31:0] wr_data [16];
    int          wr_cyc  [16];
    int          n_wr = 0;
    logic [7:0]  ob_data  [256];
    bit          ob_first [256];
    bit          ob_last  [256];
    int          ob_cyc   [256];
    int          n_ob = 0;
    logic [7:0]  exp_b [256];

    always @(posedge clk) cyc <= cyc + 1;

    // memory and sink model, all handshakes decided away from the active edge
    always @(negedge clk) begin
        if (rq.size() > 0 && (!gap_mode || gtog)) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = mem_w[rq[0][11:2]];
            void'(rq.pop_front());
        end else begin
            mem_rd_valid = 1'b0;
        end
        gtog = ~gtog;
        mem_req_ready = !stall_mode || rtog;
        rtog = ~rtog;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem_w[mem_req_addr[11:2]] = mem_req_wdata;
                if (n_wr < 16) begin
                    wr_addr[n_wr] = mem_req_addr;
                    wr_data[n_wr] = mem_req_wdata;
                    wr_cyc[n_wr]  = cyc;
                    n_wr++;
                end
            end else begin
                for (int k = 0; k < int'(mem_req_len); k++) rq.push_back(mem_req_addr + 32'(4*k));
                if (n_rd < 64) begin
                    rd_addr[n_rd] = mem_req_addr;
                    rd_len[n_rd]  = int'(mem_req_len);
                    rd_cyc[n_rd]  = cyc;
                    n_rd++;
                end
            end
        end
        out_ready = !oback || otog;
        otog = ~otog;
        if (out_valid && out_ready && n_ob < 256) begin
            ob_data[n_ob]  = out_data;
            ob_first[n_ob] = out_first;
            ob_last[n_ob]  = out_last;
            ob_cyc[n_ob]   = cyc;
            n_ob++;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_rd = 0; n_wr = 0; n_ob = 0;
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + 8'(i * 7);
    endfunction

    task automatic fill_buf(input logic [31:0] a, input int nb, input logic [7:0] seed);
        for (int w = 0; w < (nb + 3) / 4; w++)
            mem_w[a[11:2] + 10'(w)] = {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)};
    endtask

    task automatic set_desc(input logic [31:0] a, input bit own, input logic [30:0] sbits,
                            input bit first, input bit last, input int len,
                            input logic [31:0] bufp, input logic [31:0] nextp);
        mem_w[a[11:2]]       = {own, sbits};
        mem_w[a[11:2] + 10'd1] = (32'(last) << 30) | (32'(first) << 29) | (32'd1 << 24) | 32'(len);
        mem_w[a[11:2] + 10'd2] = bufp;
        mem_w[a[11:2] + 10'd3] = nextp;
    endtask

    task automatic pulse(input bit do_base, input logic [31:0] a);
        @(negedge clk); #1;
        base_wr = do_base; base_addr = a; start = 1'b1;
        @(negedge clk); #1;
        base_wr = 1'b0; start = 1'b0;
    endtask

    task automatic wait_quiet();
        int quiet = 0;
        for (int t = 0; t < 5000 && quiet < 20; t++) begin
            @(negedge clk); #2;
            if (!mem_req_valid && !out_valid && !mem_rd_valid && rq.size() == 0) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic cmp_frame(input string req, input int nb);
        chk(n_ob == nb, {req, " byte count"}, 32'(n_ob), 32'(nb));
        for (int i = 0; i < nb && i < n_ob; i++) begin
            chk(ob_data[i] == exp_b[i], {req, " byte value"}, 32'(ob_data[i]), 32'(exp_b[i]));
            chk(ob_first[i] == (i == 0), {req, " out_first"}, 32'(ob_first[i]), 32'(i == 0));
            chk(ob_last[i] == (i == nb - 1), {req, " out_last"}, 32'(ob_last[i]), 32'(i == nb - 1));
        end
    endtask

    task automatic t_reset();
        #3;
        chk(cur_desc == 32'h0, "R1 cur_desc after reset", cur_desc, 32'h0);
        chk(!mem_req_valid, "R1 no request in reset", 32'(mem_req_valid), 0);
        chk(!out_valid, "R1 no output in reset", 32'(out_valid), 0);
    endtask

    task automatic t_single();
        clear_logs();
        set_desc(32'h100, 1, 31'h1234, 1, 1, 37, 32'h402, 32'h110);
        set_desc(32'h110, 0, 31'h0055, 1, 1, 8, 32'h600, 32'h100);
        fill_buf(32'h400, 40, 8'h21);
        for (int i = 0; i < 37; i++) exp_b[i] = pat(8'h21, i);
        pulse(1, 32'h100);
        wait_quiet();
        chk(n_rd == 4, "R4 read request count", 32'(n_rd), 4);
        chk(rd_addr[0] == 32'h100 && rd_len[0] == 4, "R2 descriptor burst", rd_addr[0], 32'h100);
        chk(rd_addr[1] == 32'h400 && rd_len[1] == 8, "R4 first data burst", {rd_addr[1][27:0], 4'(rd_len[1])}, 32'h4008);
        chk(rd_addr[2] == 32'h420 && rd_len[2] == 2, "R4 tail data burst", {rd_addr[2][27:0], 4'(rd_len[2])}, 32'h4202);
        chk(rd_addr[3] == 32'h110, "R6 next pointer followed", rd_addr[3], 32'h110);
        chk(n_wr == 1 && wr_addr[0] == 32'h100, "R6 write-back address", wr_addr[0], 32'h100);
        chk(wr_data[0] == 32'h0000_1234, "R6 write-back status", wr_data[0], 32'h0000_1234);
        cmp_frame("R5 R8 single segment", 37);
        chk(cur_desc == 32'h110, "R3 stop at unowned descriptor", cur_desc, 32'h110);
        chk(mem_w[32'h110 >> 2] == 32'h0000_0055, "R3 unowned status untouched", mem_w[32'h110 >> 2], 32'h55);
    endtask

    task automatic t_multi();
        clear_logs();
        stall_mode = 1; gap_mode = 1; oback = 1;
        set_desc(32'h200, 1, 31'h0, 1, 0, 5, 32'h500, 32'h210);
        set_desc(32'h210, 1, 31'h7, 0, 0, 0, 32'h580, 32'h220);
        set_desc(32'h220, 1, 31'h0, 0, 1, 9, 32'h540, 32'h230);
        set_desc(32'h230, 0, 31'h0, 1, 1, 4, 32'h5c0, 32'h200);
        fill_buf(32'h500, 8, 8'h10);
        fill_buf(32'h540, 12, 8'h80);
        for (int i = 0; i < 5; i++) exp_b[i] = pat(8'h10, i);
        for (int i = 0; i < 9; i++) exp_b[5 + i] = pat(8'h80, i);
        pulse(1, 32'h200);
        wait_quiet();
        cmp_frame("R8 R12 three segments with stalls", 14);
        chk(n_rd == 6, "R7 read count with empty segment", 32'(n_rd), 6);
        chk(rd_addr[3] == 32'h220, "R7 empty segment reads no buffer", rd_addr[3], 32'h220);
        chk(n_wr == 3 && wr_data[1] == 32'h7, "R7 empty segment written back", wr_data[1], 32'h7);
        chk(n_ob > 0 && ob_cyc[0] > wr_cyc[2], "R9 output after closing write-back", 32'(ob_cyc[0]), 32'(wr_cyc[2]));
        chk(n_ob == 14 && rd_cyc[5] > ob_cyc[13], "R9 next fetch after drain", 32'(rd_cyc[5]), 32'(ob_cyc[13]));
        chk(cur_desc == 32'h230, "R3 suspended pointer", cur_desc, 32'h230);
        stall_mode = 0; gap_mode = 0; oback = 0;
    endtask

    task automatic t_zero();
        clear_logs();
        set_desc(32'h300, 1, 31'h40, 1, 1, 0, 32'h5e0, 32'h310);
        set_desc(32'h310, 0, 31'h0, 1, 1, 4, 32'h5e0, 32'h300);
        pulse(1, 32'h300);
        wait_quiet();
        chk(n_ob == 0, "R7 zero length emits nothing", 32'(n_ob), 0);
        chk(n_rd == 2, "R7 zero length reads only descriptors", 32'(n_rd), 2);
        chk(n_wr == 1 && wr_data[0] == 32'h40, "R7 zero length write-back", wr_data[0], 32'h40);
    endtask

    task automatic t_enable();
        clear_logs();
        set_desc(32'h340, 1, 31'h0, 1, 1, 4, 32'h700, 32'h350);
        set_desc(32'h350, 1, 31'h0, 1, 1, 4, 32'h720, 32'h360);
        set_desc(32'h360, 0, 31'h0, 1, 1, 4, 32'h740, 32'h340);
        fill_buf(32'h700, 4, 8'h33);
        fill_buf(32'h720, 4, 8'h44);
        enable = 1'b0;
        pulse(1, 32'h340);
        wait_quiet();
        chk(n_rd == 0, "R10 start ignored while disabled", 32'(n_rd), 0);
        chk(cur_desc == 32'h340, "R2 base loaded while idle", cur_desc, 32'h340);
        enable = 1'b1;
        pulse(0, 32'h0);
        while (n_rd < 1) @(negedge clk);
        #3 enable = 1'b0;
        wait_quiet();
        chk(cur_desc == 32'h350, "R10 stop at descriptor boundary", cur_desc, 32'h350);
        chk(n_wr == 1 && n_ob == 4 && n_rd == 2, "R10 current descriptor completed", 32'(n_wr), 1);
        for (int i = 0; i < 4; i++) exp_b[i] = pat(8'h33, i);
        cmp_frame("R10 finished frame", 4);
        clear_logs();
        enable = 1'b1;
        pulse(0, 32'h0);
        wait_quiet();
        for (int i = 0; i < 4; i++) exp_b[i] = pat(8'h44, i);
        cmp_frame("R11 resume at current pointer", 4);
        chk(rd_addr[0] == 32'h350, "R11 resume fetch address", rd_addr[0], 32'h350);
        chk(cur_desc == 32'h360, "R3 stop at unowned after resume", cur_desc, 32'h360);
    endtask

    task automatic t_wrap();
        clear_logs();
        set_desc(32'h380, 1, 31'h1, 1, 1, 8, 32'h760, 32'h390);
        set_desc(32'h390, 1, 31'h2, 1, 1, 8, 32'h780, 32'h380);
        fill_buf(32'h760, 8, 8'h61);
        fill_buf(32'h780, 8, 8'h91);
        pulse(1, 32'h380);
        wait_quiet();
        chk(n_wr == 2 && n_ob == 16, "R11 both loop entries served", 32'(n_ob), 16);
        chk(n_rd == 5 && rd_addr[4] == 32'h380, "R11 wrap through next pointer", rd_addr[4], 32'h380);
        chk(cur_desc == 32'h380, "R3 wrap meets returned descriptor", cur_desc, 32'h380);
        clear_logs();
        mem_w[32'h380 >> 2] = 32'h8000_0001;
        pulse(0, 32'h0);
        wait_quiet();
        for (int i = 0; i < 8; i++) exp_b[i] = pat(8'h61, i);
        cmp_frame("R11 restart by start alone", 8);
        chk(n_wr == 1 && wr_addr[0] == 32'h380, "R6 restart write-back", wr_addr[0], 32'h380);
        chk(cur_desc == 32'h390, "R11 pointer after restart", cur_desc, 32'h390);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem_w[i] = '0;
        repeat (5) @(negedge clk);
        t_reset();
        @(negedge clk); #1 rst_n = 1'b1;
        t_single();
        t_multi();
        t_zero();
        t_enable();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule